// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one memory-to-peripheral DMA channel. It holds two buffer descriptors, each made of a byte count and a start address. It moves bytes from a byte-wide memory read port to a peripheral, one byte on each accepted valid/ready handshake. Software fills the descriptors through a simple register port and takes turns between them. While one descriptor drains, the other can be refilled. When the running buffer is used up, the channel moves on to the queued buffer with no gap.

A four-state activity machine tracks the channel. The states are: disabled, running with no buffer loaded, running with one buffer loaded, and running with a second buffer queued behind the first. Two level flags follow the machine and drive a maskable interrupt. One says the channel has stalled. The other says a slot is free for the next buffer. A sticky error flag records a buffer that software loaded while both slots were already full. A 4-bit peripheral selector, which software can write only while the channel is disabled, is driven out to pick the target peripheral.

Top module: `pdma_chan`

## Requirements
- R1: After reset the state is idle, the status, control, flag and selector registers read 0, `irq` is 0 and `per_valid` is 0.
- R2: The state is reported in status bits [5:4] as idle=0, stall=1, on=2, next=3. Setting the enable bit (control bit 4) moves the state from idle to stall on the clock edge after the write.
- R3: A write to a slot start-address register (slot 0 at offset 0x24, slot 1 at 0x34) marks that slot loaded. It moves the state from stall to on, or from on to next, at the write edge. Slot byte counts are at 0x20 (slot 0) and 0x34-0x4 = 0x30 (slot 1) and must be written before the start address.
- R4: While the state is on or next and the remaining count is not zero, `per_valid` is high and `per_data` carries the memory byte at `mem_addr`. Each accepted handshake advances `mem_addr` by one and lowers the remaining count (offset 0x14) by one.
- R5: When the last byte of the running buffer is accepted in the next state, the state becomes on at that edge. `mem_addr` and the remaining count are reloaded from the queued slot.
- R6: When the last byte is accepted in the on state and no load arrives in that cycle, the state becomes stall and the remaining count reads 0.
- R7: Flag register (offset 0x04) bit 0 is 1 exactly in the stall state and bit 1 exactly in the on state. Bit 3 is the error flag. `irq` is the OR of each flag ANDed with its enable (control bits 0, 1 and 3).
- R8: A start-address write while the state is next changes no slot and sets error bit 3. That bit stays set until software writes 1 to bit 3 of offset 0x04.
- R9: Clearing the enable bit does not stop a running buffer. The channel finishes it, enters stall, and reaches idle on the following edge.
- R10: The selector register (offset 0x08, 4 bits) drives `port_sel`. Writes to it take effect only in the idle state.
- R11: A buffer loaded with a byte count of 0 issues no handshake. In the on state it completes on the edge after it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt request |
| port_sel | output | 4 | Selected peripheral identifier |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 8 | Memory read byte for `mem_addr` |
| per_valid | output | 1 | Byte available to the peripheral |
| per_data | output | 8 | Byte to the peripheral |
| per_ready | input | 1 | Peripheral accepts the byte |

## Verification
Register writes and handshakes take effect at the edge where they are presented. Address and count updates, load-driven state changes and buffer switching can all be read back in the cycle after that edge. An enable change and the stall-to-idle step each take one extra edge. The bench drives its inputs just after a rising edge and reads the combinational register port a little later. This way every readback falls exactly one or two edges after its stimulus, as each result requires. A monitor samples each handshake at the falling edge. It compares the address and byte against a queue of expected addresses that the driver filled in advance. Any handshake the queue does not expect is counted as a mismatch.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_ON    = 2'd2,
    ST_NEXT  = 2'd3
  } chan_state_t;

  localparam int unsigned NSLOT = 2;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_FLAG  = 8'h04;
  localparam logic [7:0] OFS_PORT  = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_REM   = 8'h14;
  localparam logic [7:0] OFS_CNT0  = 8'h20;
  localparam logic [7:0] OFS_BASE0 = 8'h24;
  localparam logic [7:0] OFS_CNT1  = 8'h30;
  localparam logic [7:0] OFS_BASE1 = 8'h34;

  localparam int unsigned B_STALL = 0;
  localparam int unsigned B_NFB   = 1;
  localparam int unsigned B_ERR   = 3;
  localparam int unsigned B_EN    = 4;

  function automatic logic [7:0] cnt_ofs(input logic s);
    return s ? OFS_CNT1 : OFS_CNT0;
  endfunction

  function automatic logic [7:0] base_ofs(input logic s);
    return s ? OFS_BASE1 : OFS_BASE0;
  endfunction

  function automatic logic is_base(input logic [7:0] a);
    return (a == OFS_BASE0) || (a == OFS_BASE1);
  endfunction

  function automatic logic slot_of(input logic [7:0] a);
    return a[4];
  endfunction

  function automatic logic is_busy(input chan_state_t s);
    return (s == ST_ON) || (s == ST_NEXT);
  endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PORT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [7:0]                    waddr,
  input  logic [BUS_W-1:0]              wdata,
  input  logic [7:0]                    raddr,
  output logic [BUS_W-1:0]              rdata,
  input  chan_state_t                   state,
  input  logic [CNT_W-1:0]              rem,
  output logic                          ctrl_en,
  output logic                          irq,
  output logic [PORT_W-1:0]             port_sel,
  output logic [NSLOT-1:0][CNT_W-1:0]   slot_cnt,
  output logic [NSLOT-1:0][ADDR_W-1:0]  slot_base,
  output logic                          load_req,
  output logic                          load_slot,
  output logic [ADDR_W-1:0]             load_base
);

  logic [4:0]        ctrl_q;
  logic [PORT_W-1:0] port_q;
  logic              err_q;
  logic              slot_wr_ok;
  logic              err_set;
  logic              err_clr;
  logic              flag_stall;
  logic              flag_nfb;
  logic [3:0]        flag_vec;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign slot_wr_ok = wr_en && (state != ST_NEXT);
  assign load_req   = slot_wr_ok && is_base(waddr);
  assign load_slot  = slot_of(waddr);
  assign load_base  = wdata[ADDR_W-1:0];
  assign err_set    = wr_en && is_base(waddr) && (state == ST_NEXT);
  assign err_clr    = wr_en && (waddr == OFS_FLAG) && wdata[B_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && waddr == OFS_CTRL)
        ctrl_q <= {wdata[B_EN], wdata[B_ERR], 1'b0, wdata[B_NFB], wdata[B_STALL]};
      if (wr_en && waddr == OFS_PORT && state == ST_IDLE)
        port_q <= wdata[PORT_W-1:0];
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt  <= '0;
      slot_base <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_wr_ok && waddr == cnt_ofs(1'(s)))
          slot_cnt[s] <= wdata[CNT_W-1:0];
        if (slot_wr_ok && waddr == base_ofs(1'(s)))
          slot_base[s] <= wdata[ADDR_W-1:0];
      end
    end
  end

  assign flag_stall = (state == ST_STALL);
  assign flag_nfb   = (state == ST_ON);
  assign flag_vec   = {err_q, 1'b0, flag_nfb, flag_stall};
  assign irq        = |(flag_vec & ctrl_q[3:0]);
  assign ctrl_en    = ctrl_q[4];
  assign port_sel   = port_q;

  always_comb begin
    unique case (raddr)
      OFS_CTRL:  rdata = BUS_W'(ctrl_q);
      OFS_FLAG:  rdata = BUS_W'(flag_vec);
      OFS_PORT:  rdata = BUS_W'(port_q);
      OFS_STAT:  rdata = BUS_W'({state, 4'b0000});
      OFS_REM:   rdata = BUS_W'(rem);
      OFS_CNT0:  rdata = BUS_W'(slot_cnt[0]);
      OFS_BASE0: rdata = BUS_W'(slot_base[0]);
      OFS_CNT1:  rdata = BUS_W'(slot_cnt[1]);
      OFS_BASE1: rdata = BUS_W'(slot_base[1]);
      default:   rdata = '0;
    endcase
  end

  // R8: error flag holds until software clears it
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  // R10: selector frozen outside idle
  p_port_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(port_q));

  // R8: slot storage untouched while both slots are full
  p_next_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT) |=> $stable(slot_base));

endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
  import pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        load_req,
  input  logic        load_slot,
  input  logic        done,
  output chan_state_t state,
  output logic        start,
  output logic        start_slot,
  output logic        start_from_wr
);

  chan_state_t nxt;
  logic        pend_q;

  always_comb begin
    nxt           = state;
    start         = 1'b0;
    start_slot    = pend_q;
    start_from_wr = 1'b0;
    unique case (state)
      ST_IDLE: if (en) nxt = ST_STALL;
      ST_STALL: begin
        if (!en) nxt = ST_IDLE;
        else if (load_req) begin
          nxt = ST_ON; start = 1'b1; start_slot = load_slot; start_from_wr = 1'b1;
        end
      end
      ST_ON: begin
        if (done && load_req) begin
          start = 1'b1; start_slot = load_slot; start_from_wr = 1'b1;
        end else if (done) nxt = ST_STALL;
        else if (load_req) nxt = ST_NEXT;
      end
      ST_NEXT: if (done) begin
        nxt = ST_ON; start = 1'b1; start_slot = pend_q;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_ON && !done && load_req) pend_q <= load_slot;
    end
  end

  // R2: idle leaves only toward stall
  p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_STALL));

  // R9: a running buffer never drops straight to idle
  p_busy_no_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_busy(state) |=> (state != ST_IDLE));

  // R5: queued buffer takes over on completion
  p_next_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT && done) |=> (state == ST_ON));

endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              per_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  rem,
  output logic              per_valid,
  output logic              hs,
  output logic              done
);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  assign per_valid = active && (rem != '0);
  assign hs        = per_valid && per_ready;
  assign done      = active && ((rem == '0) || (hs && rem == CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      rem      <= '0;
    end else if (start) begin
      mem_addr <= start_addr;
      rem      <= start_cnt;
    end else if (hs) begin
      mem_addr <= addr_step(mem_addr);
      rem      <= cnt_step(rem);
    end
  end

  // R4: each handshake consumes one byte of the count
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !start) |=> (rem == CNT_W'($past(rem) - 1'b1)));

  // R4: each handshake advances the address
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !start) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_waddr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic [7:0]        reg_raddr,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq,
  output logic [PORT_W-1:0] port_sel,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              per_valid,
  output logic [7:0]        per_data,
  input  logic              per_ready
);

  chan_state_t                  state;
  logic [CNT_W-1:0]             rem;
  logic                         ctrl_en;
  logic [NSLOT-1:0][CNT_W-1:0]  slot_cnt;
  logic [NSLOT-1:0][ADDR_W-1:0] slot_base;
  logic                         load_req;
  logic                         load_slot;
  logic [ADDR_W-1:0]            load_base;
  logic                         start;
  logic                         start_slot;
  logic                         start_from_wr;
  logic                         done;
  logic                         hs;
  logic [ADDR_W-1:0]            start_addr;

  pdma_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .state(state), .rem(rem),
    .ctrl_en(ctrl_en), .irq(irq), .port_sel(port_sel),
    .slot_cnt(slot_cnt), .slot_base(slot_base),
    .load_req(load_req), .load_slot(load_slot), .load_base(load_base)
  );

  pdma_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .load_req(load_req), .load_slot(load_slot),
    .done(done), .state(state), .start(start), .start_slot(start_slot),
    .start_from_wr(start_from_wr)
  );

  // the address written this cycle is not yet in storage: bypass it
  assign start_addr = start_from_wr ? load_base : slot_base[start_slot];

  pdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .active(is_busy(state)), .start(start),
    .start_addr(start_addr), .start_cnt(slot_cnt[start_slot]), .per_ready(per_ready),
    .mem_addr(mem_addr), .rem(rem), .per_valid(per_valid), .hs(hs), .done(done)
  );

  assign per_data = mem_rdata;

  // R6: finishing with nothing queued stalls the channel
  p_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON && done && !load_req) |=> (state == ST_STALL && rem == '0));

  // R7: no request while the flags are all clear
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT && reg_rdata == '0 && reg_raddr == OFS_FLAG) |-> !irq);

endmodule

// File: tb/pdma_chan_bench.sv
`timescale 1ns/1ps
module pdma_chan_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [3:0]  port_sel;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        per_valid;
  logic [7:0]  per_data;
  logic        per_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] d;

  always #10 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  pdma_chan u_pdma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .irq(irq), .port_sel(port_sel), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .per_valid(per_valid), .per_data(per_data), .per_ready(per_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_raddr = a; #1; v = reg_rdata;
  endtask

  task automatic push_run(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(base + i);
  endtask

  // scoreboard monitor: every accepted byte must be the next expected one
  always @(negedge clk) begin
    if (rst_n && per_valid && per_ready) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected handshake addr", mem_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea;
        ea = exp_q.pop_front();
        chk("R4 handshake address", mem_addr, ea);
        chk("R4 handshake data", {24'h0, per_data}, {24'h0, ea[7:0] ^ 8'hA5});
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(8'h0C, d); chk("R1 status", d, 32'h0);
    rd(8'h00, d); chk("R1 control", d, 32'h0);
    rd(8'h04, d); chk("R1 flags", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 per_valid", {31'b0, per_valid}, 32'h0);
    chk("R1 port_sel", {28'b0, port_sel}, 32'h0);

    // R10 selector writable while idle
    wr(8'h08, 32'h5);
    chk("R10 port_sel idle write", {28'b0, port_sel}, 32'h5);

    // R2 enable with all interrupt enables
    wr(8'h00, 32'h1B);
    rd(8'h0C, d); chk("R2 still idle after enable edge", d, 32'h00);
    tick();
    rd(8'h0C, d); chk("R2 stall", d, 32'h10);
    rd(8'h04, d); chk("R7 stall flag", d, 32'h1);
    chk("R7 irq on stall", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h9);
    chk("R10 selector ignored outside idle", {28'b0, port_sel}, 32'h5);

    // R3 load slot 0 then slot 1
    wr(8'h20, 32'd4); wr(8'h24, 32'h100);
    rd(8'h0C, d); chk("R3 stall to on", d, 32'h20);
    rd(8'h14, d); chk("R4 remaining after load", d, 32'd4);
    rd(8'h04, d); chk("R7 next-buffer flag", d, 32'h2);
    chk("R4 mem_addr at start", mem_addr, 32'h100);
    wr(8'h30, 32'd3); wr(8'h34, 32'h200);
    rd(8'h0C, d); chk("R3 on to next", d, 32'h30);
    rd(8'h04, d); chk("R7 no flags in next", d, 32'h0);
    chk("R7 irq quiet in next", {31'b0, irq}, 32'h0);

    // R8 overload while next
    wr(8'h24, 32'h777);
    rd(8'h04, d); chk("R8 error flag", d, 32'h8);
    chk("R8 irq on error", {31'b0, irq}, 32'h1);
    rd(8'h24, d); chk("R8 slot0 base unchanged", d, 32'h100);
    rd(8'h0C, d); chk("R8 state unchanged", d, 32'h30);
    wr(8'h04, 32'h8);
    rd(8'h04, d); chk("R8 error cleared", d, 32'h0);

    // R4 R5 R6 drain both slots
    push_run(32'h100, 4);
    push_run(32'h200, 3);
    per_ready = 1'b1;
    repeat (4) tick();
    rd(8'h0C, d); chk("R5 next to on", d, 32'h20);
    rd(8'h14, d); chk("R5 remaining reloaded", d, 32'd3);
    chk("R5 address switched", mem_addr, 32'h200);
    repeat (3) tick();
    rd(8'h0C, d); chk("R6 on to stall", d, 32'h10);
    rd(8'h14, d); chk("R6 remaining zero", d, 32'd0);
    chk("R4 all bytes seen", exp_q.size(), 32'd0);

    // R11 zero-length buffer
    wr(8'h20, 32'd0); wr(8'h24, 32'h300);
    rd(8'h0C, d); chk("R11 zero buffer on", d, 32'h20);
    chk("R11 no valid", {31'b0, per_valid}, 32'h0);
    tick();
    rd(8'h0C, d); chk("R11 zero buffer completes", d, 32'h10);

    // R9 disable with a buffer in flight
    push_run(32'h400, 2);
    wr(8'h30, 32'd2); wr(8'h34, 32'h400);
    wr(8'h00, 32'h03);
    rd(8'h0C, d); chk("R9 keeps running after disable", d, 32'h20);
    tick();
    rd(8'h0C, d); chk("R9 passes through stall", d, 32'h10);
    tick();
    rd(8'h0C, d); chk("R9 reaches idle", d, 32'h00);
    chk("R9 disabled buffer drained", exp_q.size(), 32'd0);

    // R7 masking: enable without interrupt enables
    per_ready = 1'b0;
    wr(8'h00, 32'h10);
    tick();
    rd(8'h04, d); chk("R7 stall flag unmasked view", d, 32'h1);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);

    summary();
    $finish;
  end

endmodule